// File: doc/BRIEF.md
# Bitmask Immediate Pattern Decoder

This block turns a 13-bit logical-immediate code into a 64-bit constant for a logic unit. The code names an element width (a power of two from 2 to 64 bits), how many ones sit at the bottom of that element, and a right rotation. The decoder builds one element holding a contiguous run of ones from bit 0 upward, repeats it until the word is full, and then rotates the whole word right.

Some codes have no meaning: codes that name no legal element width, and codes whose run would fill the entire element. For these codes the block lowers `imm_valid`, and the consumer must then ignore `imm_value`. The block is purely combinational. The element width is chosen by the highest set bit of the wide flag placed above the inverted run field, so wide elements can hold long runs and narrow elements hold short runs.

Top module: `bmi_decoder`

## Requirements
- R1: The code is packed as bit 12 = wide flag, bits 11:6 = rotation field, bits 5:0 = run field. The element width is 2^k, where k is the index of the highest set bit of the 7-bit vector {wide flag, inverted run field}.
- R2: Within one element, bits 0 through (run field mod element width) are one and every higher bit is zero.
- R3: The element is repeated 64 / element-width times to fill the word.
- R4: The repeated word is rotated right by (rotation field mod element width).
- R5: A code whose run would cover the whole element (run field mod element width equal to element width minus 1) drives `imm_valid` low.
- R6: A code with the wide flag clear and run field 6'b111110 or 6'b111111 has no legal width, and `imm_valid` is low.
- R7: Whenever `imm_valid` is high, `imm_value` is neither all zeros nor all ones.
- R8: The code with the wide flag set, run field 0 and rotation r gives a single set bit at position (64 - r) mod 64.
- R9: The code with the wide flag set, run field 62 and rotation r gives a word whose only clear bit is at position (63 - r) mod 64.
- R10: The outputs depend on the code alone, with no clock edge in between: a new code shows its result in the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code | input | 13 | Packed immediate description: {wide flag, rotation field, run field} |
| imm_value | output | 64 | Decoded constant. It has no meaning when imm_valid is low |
| imm_valid | output | 1 | High when the code is encodable |

## Verification
The bench builds the block at its default 64-bit word with the staged rotator. At this width the full code space has only 8192 entries, so every code is swept against a loop-based model in the bench. This sweep covers every element width, every run length and every rotation, along with all illegal codes. A vector table and directed cases pin down the single-bit and single-hole words, the modulo behaviour of the rotation, and the combinational response.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
   // Rotator implementation options
   typedef enum int {
      ROT_STAGED = 0,   // log2(W) stages of 2:1 muxes
      ROT_FOLD   = 1    // double-width word shifted once
   } bmi_rot_e;

   localparam int BMI_DEF_WORD_W = 64;
endpackage

// File: rtl/bmi_size_dec.sv
// Finds the element width from the wide flag and the inverted run field.
module bmi_size_dec #(
   parameter int LOG_W = 6,
   localparam int LEN_W = $clog2(LOG_W + 1)
) (
   input  logic             wide,
   input  logic [LOG_W-1:0] run_fld,
   output logic [LEN_W-1:0] len,
   output logic [LOG_W-1:0] lvl,
   output logic             size_ok
);
   logic [LOG_W:0] probe;
   logic           found;

   assign probe = {wide, ~run_fld};

   always_comb begin
      len   = '0;
      found = 1'b0;
      for (int b = 0; b <= LOG_W; b++) begin
         if (probe[b]) begin
            len   = LEN_W'(b);
            found = 1'b1;
         end
      end
   end

   // Mask of element-index bits: low len bits set
   always_comb begin
      for (int b = 0; b < LOG_W; b++) begin
         lvl[b] = (b < int'(len));
      end
   end

   // A width of one bit is not a legal element
   assign size_ok = found && (len != '0);
endmodule

// File: rtl/bmi_elem_gen.sv
// Builds the repeated run-of-ones word for each width, then picks one.
module bmi_elem_gen #(
   parameter int WORD_W = 64,
   localparam int LOG_W = $clog2(WORD_W),
   localparam int LEN_W = $clog2(LOG_W + 1)
) (
   input  logic [LOG_W-1:0]  run_fld,
   input  logic [LEN_W-1:0]  len,
   output logic [WORD_W-1:0] filled
);
   logic [WORD_W-1:0] pat [LOG_W+1];

   assign pat[0] = '0;

   for (genvar k = 1; k <= LOG_W; k++) begin : g_width
      localparam int ES   = 1 << k;
      localparam int REPS = WORD_W / ES;
      logic [k-1:0]  top_idx;
      logic [ES-1:0] elem;

      assign top_idx = run_fld[k-1:0];

      for (genvar i = 0; i < ES; i++) begin : g_bit
         assign elem[i] = (int'(top_idx) >= i);
      end

      assign pat[k] = {REPS{elem}};
   end

   always_comb begin
      filled = '0;
      for (int k = 0; k <= LOG_W; k++) begin
         if (int'(len) == k) filled = pat[k];
      end
   end
endmodule

// File: rtl/bmi_rotator.sv
// Right rotation of a full word, variant picked by parameter.
module bmi_rotator
   import bmi_pkg::*;
#(
   parameter int       WORD_W = 64,
   parameter bmi_rot_e IMPL   = ROT_STAGED,
   localparam int      LOG_W  = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] din,
   input  logic [LOG_W-1:0]  amt,
   output logic [WORD_W-1:0] dout
);
   if (IMPL == ROT_STAGED) begin : g_staged
      logic [WORD_W-1:0] stg [LOG_W+1];
      assign stg[0] = din;
      for (genvar j = 0; j < LOG_W; j++) begin : g_stage
         localparam int SH = 1 << j;
         assign stg[j+1] = amt[j] ? {stg[j][SH-1:0], stg[j][WORD_W-1:SH]}
                                  : stg[j];
      end
      assign dout = stg[LOG_W];
   end else begin : g_fold
      logic [2*WORD_W-1:0] dbl;
      assign dbl  = {din, din} >> amt;
      assign dout = dbl[WORD_W-1:0];
   end
endmodule

// File: rtl/bmi_decoder.sv
// Top: decodes {wide, rotation, run} into a repeated, rotated bitmask.
module bmi_decoder
   import bmi_pkg::*;
#(
   parameter int       WORD_W   = BMI_DEF_WORD_W,
   parameter bmi_rot_e ROT_IMPL = ROT_STAGED,
   localparam int      LOG_W    = $clog2(WORD_W),
   localparam int      LEN_W    = $clog2(LOG_W + 1),
   localparam int      CODE_W   = 1 + 2 * LOG_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] imm_value,
   output logic              imm_valid
);
   if (WORD_W < 4 || (1 << LOG_W) != WORD_W) begin : g_bad_width
      $error("bmi_decoder: WORD_W must be a power of two of at least 4");
   end

   logic             wide;
   logic [LOG_W-1:0] rot_fld;
   logic [LOG_W-1:0] run_fld;
   logic [LEN_W-1:0] len;
   logic [LOG_W-1:0] lvl;
   logic             size_ok;
   logic [WORD_W-1:0] filled;
   logic [LOG_W-1:0] rot_amt;

   assign wide    = code[CODE_W-1];
   assign rot_fld = code[2*LOG_W-1:LOG_W];
   assign run_fld = code[LOG_W-1:0];

   bmi_size_dec #(.LOG_W(LOG_W)) i_size (
      .wide    (wide),
      .run_fld (run_fld),
      .len     (len),
      .lvl     (lvl),
      .size_ok (size_ok)
   );

   bmi_elem_gen #(.WORD_W(WORD_W)) i_elem (
      .run_fld (run_fld),
      .len     (len),
      .filled  (filled)
   );

   assign rot_amt = rot_fld & lvl;

   bmi_rotator #(.WORD_W(WORD_W), .IMPL(ROT_IMPL)) i_rot (
      .din  (filled),
      .amt  (rot_amt),
      .dout (imm_value)
   );

   // Reject a run that would fill its element
   assign imm_valid = size_ok && ((run_fld & lvl) != lvl);
endmodule

// File: rtl/bmi_decoder_chk.sv
module bmi_decoder_chk #(
   parameter int  WORD_W = 64,
   localparam int LOG_W  = $clog2(WORD_W),
   localparam int CODE_W = 1 + 2 * LOG_W
) (
   input logic [CODE_W-1:0] code,
   input logic [WORD_W-1:0] imm_value,
   input logic              imm_valid
);
   logic             c_wide;
   logic [LOG_W-1:0] c_rot;
   logic [LOG_W-1:0] c_run;
   assign c_wide = code[CODE_W-1];
   assign c_rot  = code[2*LOG_W-1:LOG_W];
   assign c_run  = code[LOG_W-1:0];

   always_comb begin
      if (!$isunknown({code, imm_value, imm_valid})) begin
         // R7
         not_zero_chk: assert (!imm_valid || imm_value != '0);
         // R7
         not_ones_chk: assert (!imm_valid || imm_value != '1);
         // R5
         full_run_chk: assert (!(c_wide && c_run == '1) || !imm_valid);
         // R6
         no_width_chk: assert (!(!c_wide && c_run[LOG_W-1:1] == '1) || !imm_valid);
         // R8
         single_bit_chk: assert (!(c_wide && c_run == '0) ||
                                 (imm_valid && $onehot(imm_value) &&
                                  imm_value[LOG_W'(WORD_W - int'(c_rot))]));
         // R9
         single_hole_chk: assert (!(c_wide && c_run == LOG_W'(WORD_W - 2)) ||
                                  (imm_valid && $countones(~imm_value) == 1));
      end
   end
endmodule

bind bmi_decoder bmi_decoder_chk #(.WORD_W(WORD_W)) i_bmi_chk (
   .code      (code),
   .imm_value (imm_value),
   .imm_valid (imm_valid)
);

// File: tb/test_bmi_decoder.sv
module test_bmi_decoder;
   localparam int W  = 64;
   localparam int CW = 13;
   localparam int NV = 17;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CW-1:0] code = '0;
   logic [W-1:0]  imm_value;
   logic          imm_valid;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bmi_decoder i_bmi_decoder (
      .code      (code),
      .imm_value (imm_value),
      .imm_valid (imm_valid)
   );

   // Code = {wide, rotation[5:0], run[5:0]}
   localparam logic [CW-1:0] V_CODE [NV] = '{
      13'h0000, 13'h1000, 13'h1040, 13'h103E, 13'h1FFE, 13'h003C,
      13'h007C, 13'h003D, 13'h003E, 13'h003F, 13'h0038, 13'h003A,
      13'h017A, 13'h0027, 13'h103F, 13'h101F, 13'h181F };
   localparam logic V_OK [NV] = '{
      1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
      1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1 };
   localparam logic [W-1:0] V_VAL [NV] = '{
      64'h0000000100000001, 64'h0000000000000001, 64'h8000000000000000,
      64'h7FFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFE, 64'h5555555555555555,
      64'hAAAAAAAAAAAAAAAA, 64'h0, 64'h0, 64'h0,
      64'h1111111111111111, 64'h7777777777777777, 64'hBBBBBBBBBBBBBBBB,
      64'h00FF00FF00FF00FF, 64'h0, 64'h00000000FFFFFFFF,
      64'hFFFFFFFF00000000 };
   localparam string V_TAG [NV] = '{
      "R3", "R8", "R8", "R9", "R9", "R1", "R4", "R5", "R6", "R6",
      "R2", "R2", "R4", "R3", "R5", "R2", "R4" };

   task automatic check(input string tag, input logic ev, input logic [W-1:0] ex);
      checks++;
      if (imm_valid !== ev || (ev && imm_value !== ex)) begin
         errors++;
         $display("FAIL %s code=%h got valid=%b value=%h expected valid=%b value=%h",
                  tag, code, imm_valid, imm_value, ev, ex);
      end
   endtask

   // Loop-based model built from the requirements
   task automatic model(input logic [CW-1:0] c, output logic ok, output logic [W-1:0] v);
      logic [6:0] probe;
      int k, es, s, r;
      logic [W-1:0] base;
      probe = {c[12], ~c[5:0]};
      k = -1;
      for (int b = 0; b < 7; b++) if (probe[b]) k = b;
      v = '0;
      ok = 1'b0;
      if (k >= 1) begin
         es = 1 << k;
         s = int'(c[5:0]) % es;
         r = int'(c[11:6]) % es;
         ok = (s != es - 1);
         for (int i = 0; i < W; i++) base[i] = ((i % es) <= s);
         for (int i = 0; i < W; i++) v[i] = base[(i + r) % W];
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R10 got cycles=%0d expected completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic          ok;
      logic [W-1:0]  ev;
      // Output during reset with code zero (R3)
      repeat (3) @(negedge clk);
      check("R3", 1'b1, 64'h0000000100000001);
      rst = 1'b0;

      // Vector table
      for (int n = 0; n < NV; n++) begin
         @(negedge clk);
         code = V_CODE[n];
         #2;
         check(V_TAG[n], V_OK[n], V_VAL[n]);
      end

      // R10: response without any clock edge between drive and sample
      @(negedge clk);
      code = 13'h1000;
      #1;
      check("R10", 1'b1, 64'h1);
      code = 13'h1040;
      #1;
      check("R10", 1'b1, 64'h8000000000000000);

      // R8 / R9 at every rotation
      for (int r = 0; r < W; r++) begin
         @(negedge clk);
         code = {1'b1, 6'(r), 6'd0};
         #2;
         check("R8", 1'b1, W'(1) << ((W - r) % W));
         code = {1'b1, 6'(r), 6'd62};
         #2;
         check("R9", 1'b1, ~(W'(1) << ((W - 1 - r) % W)));
      end

      // Full sweep of all codes (R1..R7)
      for (int c = 0; c < (1 << CW); c++) begin
         @(negedge clk);
         code = CW'(c);
         #2;
         model(CW'(c), ok, ev);
         check("R1_R4", ok, ev);
         if (imm_valid) begin
            checks++;
            if (imm_value == '0 || imm_value == '1) begin
               errors++;
               $display("FAIL R7 code=%h got value=%h expected neither all-zero nor all-one",
                        code, imm_value);
            end
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule